// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small single-issue core: the global interrupt enable, a one-bit scratch cell used by bit-copy instructions, and the six arithmetic condition flags. Each cycle it merges the flag results of the arithmetic unit under a per-flag update mask. It sequences the interrupt enable from the interrupt controller and the instruction decoder. It also accepts a whole-word load from the memory-mapped register port.

The sign flag is never stored on its own terms. It is always derived as the exclusive-or of the negative and overflow flags, whether the word was updated by the arithmetic unit or written through the port. The bit-copy path lets a decoded bit-store take any selected bit of a register operand into the scratch cell. The bit-load path returns a register operand with one selected bit replaced by that cell.

The block does not save or restore the word on interrupt entry or return; that is left to software.

Top module: `cpu_flag_reg`

## Requirements
- R1: After a synchronous active-low reset, all eight bits of the status word read 0 and the scratch output reads 0.
- R2: Bit positions of the status word are fixed: bit 7 interrupt enable, bit 6 scratch (also on `t_bit`), bit 5 half carry, bit 4 sign, bit 3 overflow, bit 2 negative, bit 1 zero, bit 0 carry.
- R3: When `alu_valid` is high, each arithmetic flag whose mask bit is set takes the matching `alu_*` input on the next edge; mask bit 0 selects carry, 1 zero, 2 negative, 3 overflow, 4 half carry. Flags with a clear mask bit, and all flags when `alu_valid` is low, keep their value.
- R4: After every update, the sign bit equals negative xor overflow.
- R5: `irq_take` clears the interrupt enable on the next edge.
- R6: `irq_return` and `ie_set` each set the interrupt enable on the next edge.
- R7: `ie_clear` clears the interrupt enable. When several enable controls occur together, `irq_take` wins over `ie_clear`, which wins over `irq_return` and `ie_set`.
- R8: `bst_en` loads the scratch bit with bit `bst_sel` of `bst_operand` on the next edge.
- R9: `bld_result` equals `bld_operand` with bit `bld_sel` replaced by the current scratch bit; all other bits pass unchanged, with no clock delay.
- R10: `port_wr` loads all bits from `port_wdata` except the sign bit, which is set to `port_wdata[2]` xor `port_wdata[3]`. A port write overrides every ALU, enable and bit-store update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_valid | input | 1 | ALU result present this cycle |
| alu_mask | input | 5 | Per-flag update mask (H,V,N,Z,C from bit 4 to bit 0) |
| alu_c | input | 1 | Carry result |
| alu_h | input | 1 | Half-carry result |
| alu_v | input | 1 | Overflow result |
| alu_n | input | 1 | Negative result |
| alu_z | input | 1 | Zero result |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| ie_set | input | 1 | Set-enable command |
| ie_clear | input | 1 | Clear-enable command |
| bst_en | input | 1 | Bit-store command |
| bst_operand | input | DATA_W | Register operand for bit-store |
| bst_sel | input | SEL_W | Bit index for bit-store |
| bld_operand | input | DATA_W | Register operand for bit-load |
| bld_sel | input | SEL_W | Bit index for bit-load |
| bld_result | output | DATA_W | Operand with selected bit replaced by scratch |
| port_wr | input | 1 | Memory-mapped write strobe |
| port_wdata | input | 8 | Memory-mapped write data |
| flags_q | output | 8 | Full status word |
| t_bit | output | 1 | Scratch bit |

## Verification
The bench builds the block with a 16-bit register operand, so the bit-store and bit-load select reaches indices above 7, including the top bit 15. The flag word itself is fixed at eight bits. A vector table steps through masked ALU updates, enable sequencing with simultaneous controls, and port writes that collide with other updates. Directed tests then cover the bit-copy paths and a reset applied mid-run.

// File: rtl/flag_pkg.sv
// Package: shared bit positions and types for the status flag register.
// Assumes an 8-bit status word with the layout fixed by requirement R2.
package flag_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned B_IE   = 7;
    localparam int unsigned B_T    = 6;
    localparam int unsigned B_H    = 5;
    localparam int unsigned B_S    = 4;
    localparam int unsigned B_V    = 3;
    localparam int unsigned B_N    = 2;
    localparam int unsigned B_Z    = 1;
    localparam int unsigned B_C    = 0;
    localparam int unsigned ARITH_W = 5;

    // Maskable arithmetic flags; packed order matches alu_mask bits 4..0.
    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } aflags_t;
endpackage

// File: rtl/flag_arith_merge.sv
// Module: merges ALU flag results into the held arithmetic flags under a
// per-flag mask, and derives the sign flag from the merged N and V.
// Assumes the mask bit order of flag_pkg::aflags_t.
module flag_arith_merge
    import flag_pkg::*;
(
    input  logic                alu_valid,
    input  logic [ARITH_W-1:0]  alu_mask,
    input  aflags_t             alu_in,
    input  aflags_t             cur,
    output aflags_t             nxt,
    output logic                sign_nxt
);
    logic [ARITH_W-1:0] cur_v;
    logic [ARITH_W-1:0] alu_v;
    logic [ARITH_W-1:0] nxt_v;

    assign cur_v = cur;
    assign alu_v = alu_in;

    // One selector per maskable flag.
    for (genvar gi = 0; gi < ARITH_W; gi++) begin : g_flag
        assign nxt_v[gi] = (alu_valid && alu_mask[gi]) ? alu_v[gi] : cur_v[gi];
    end

    assign nxt = nxt_v;

    // Sign is always recomputed from the flags that will be held.
    assign sign_nxt = nxt.n ^ nxt.v;
endmodule

// File: rtl/flag_ie_seq.sv
// Module: next value of the global interrupt enable.
// Priority: entry strobe, then clear command, then return/set.
// Assumes strobes are single-cycle pulses from decode or interrupt logic.
module flag_ie_seq (
    input  logic ie_cur,
    input  logic irq_take,
    input  logic irq_return,
    input  logic ie_set,
    input  logic ie_clear,
    output logic ie_nxt
);
    // Resolve simultaneous enable controls by fixed priority.
    always_comb begin
        if (irq_take)
            ie_nxt = 1'b0;
        else if (ie_clear)
            ie_nxt = 1'b0;
        else if (irq_return || ie_set)
            ie_nxt = 1'b1;
        else
            ie_nxt = ie_cur;
    end
endmodule

// File: rtl/flag_bit_copy.sv
// Module: bit-store extraction into the scratch bit and bit-load insertion
// of the scratch bit into a register operand.
// Assumes DATA_W is a power of two so every select value is in range.
module flag_bit_copy #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              t_cur,
    input  logic              bst_en,
    input  logic [DATA_W-1:0] bst_operand,
    input  logic [SEL_W-1:0]  bst_sel,
    input  logic [DATA_W-1:0] bld_operand,
    input  logic [SEL_W-1:0]  bld_sel,
    output logic              t_nxt,
    output logic [DATA_W-1:0] bld_result
);
    // Bit-store: pick the selected operand bit when commanded.
    always_comb begin
        t_nxt = bst_en ? bst_operand[bst_sel] : t_cur;
    end

    // Bit-load: one replace-or-pass cell per operand bit.
    for (genvar gb = 0; gb < DATA_W; gb++) begin : g_ins
        assign bld_result[gb] = (bld_sel == SEL_W'(gb)) ? t_cur : bld_operand[gb];
    end
endmodule

// File: rtl/cpu_flag_reg.sv
// Module: top of the status flag register. Holds the 8-bit word, applies
// the port write with priority over all other updates, and otherwise
// combines ALU flags, interrupt enable and scratch-bit updates.
// Assumes synchronous active-low reset; no context save on interrupts.
module cpu_flag_reg
    import flag_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [4:0]        alu_mask,
    input  logic              alu_c,
    input  logic              alu_h,
    input  logic              alu_v,
    input  logic              alu_n,
    input  logic              alu_z,
    input  logic              irq_take,
    input  logic              irq_return,
    input  logic              ie_set,
    input  logic              ie_clear,
    input  logic              bst_en,
    input  logic [DATA_W-1:0] bst_operand,
    input  logic [SEL_W-1:0]  bst_sel,
    input  logic [DATA_W-1:0] bld_operand,
    input  logic [SEL_W-1:0]  bld_sel,
    output logic [DATA_W-1:0] bld_result,
    input  logic              port_wr,
    input  logic [7:0]        port_wdata,
    output logic [7:0]        flags_q,
    output logic              t_bit
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    aflags_t           alu_in;
    aflags_t           arith_cur;
    aflags_t           arith_nxt;
    logic              sign_nxt;
    logic              ie_nxt;
    logic              t_nxt;

    assign alu_in    = '{h: alu_h, v: alu_v, n: alu_n, z: alu_z, c: alu_c};
    assign arith_cur = '{h: word_q[B_H], v: word_q[B_V], n: word_q[B_N],
                         z: word_q[B_Z], c: word_q[B_C]};

    flag_arith_merge u_arith (
        .alu_valid (alu_valid),
        .alu_mask  (alu_mask),
        .alu_in    (alu_in),
        .cur       (arith_cur),
        .nxt       (arith_nxt),
        .sign_nxt  (sign_nxt)
    );

    flag_ie_seq u_ie (
        .ie_cur     (word_q[B_IE]),
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .ie_set     (ie_set),
        .ie_clear   (ie_clear),
        .ie_nxt     (ie_nxt)
    );

    flag_bit_copy #(.DATA_W(DATA_W)) u_copy (
        .t_cur       (word_q[B_T]),
        .bst_en      (bst_en),
        .bst_operand (bst_operand),
        .bst_sel     (bst_sel),
        .bld_operand (bld_operand),
        .bld_sel     (bld_sel),
        .t_nxt       (t_nxt),
        .bld_result  (bld_result)
    );

    // Select the next word: port write first, else per-field updates.
    always_comb begin
        word_d = word_q;
        if (port_wr) begin
            word_d      = port_wdata;
            word_d[B_S] = port_wdata[B_N] ^ port_wdata[B_V];
        end else begin
            word_d[B_IE] = ie_nxt;
            word_d[B_T]  = t_nxt;
            word_d[B_H]  = arith_nxt.h;
            word_d[B_S]  = sign_nxt;
            word_d[B_V]  = arith_nxt.v;
            word_d[B_N]  = arith_nxt.n;
            word_d[B_Z]  = arith_nxt.z;
            word_d[B_C]  = arith_nxt.c;
        end
    end

    // Hold the status word; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    assign flags_q = word_q;
    assign t_bit   = word_q[B_T];

    // R4: held sign always consistent with held N and V.
    a_r4_sign_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[B_S] == (flags_q[B_N] ^ flags_q[B_V]));

    // R10: port write loads every bit other than sign.
    a_r10_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (flags_q[7:5] == $past(port_wdata[7:5]))
                 && (flags_q[3:0] == $past(port_wdata[3:0])));

    // R5: entry strobe clears the enable unless a port write overrides.
    a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !port_wr) |=> !flags_q[B_IE]);

    // R6: return or set raises the enable when no higher control is present.
    a_r6_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_return || ie_set) && !irq_take && !ie_clear && !port_wr)
            |=> flags_q[B_IE]);

    // R3: with no ALU result and no port write, arithmetic flags hold.
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_valid && !port_wr) |=> $stable(flags_q[5:0]));

    // R8: bit-store lands the selected operand bit in the scratch bit.
    a_r8_bit_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !port_wr) |=> (t_bit == $past(bst_operand[bst_sel])));
endmodule

// File: tb/cpu_flag_reg_bench.sv
module cpu_flag_reg_bench;
    localparam int unsigned DW = 16;
    localparam int unsigned SW = 4;
    localparam int NVEC = 16;

    // Vector: [31] port_wr, [30:23] port data, [22] alu_valid,
    // [21:17] mask, [16:12] alu {h,v,n,z,c}, [11:8] {take,ret,set,clr},
    // [7:0] expected word after the edge.
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 1'b1, 5'b11111, 5'b10101, 4'b0000, 8'h35}, // R3 R4
        {1'b0, 8'h00, 1'b1, 5'b00010, 5'b01010, 4'b0000, 8'h37}, // R3 only Z
        {1'b0, 8'h00, 1'b1, 5'b01000, 5'b01000, 4'b0000, 8'h2F}, // R4 S drops
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b0010, 8'hAF}, // R6 set
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b1000, 8'h2F}, // R5 take
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b0100, 8'hAF}, // R6 return
        {1'b0, 8'h00, 1'b1, 5'b00001, 5'b00000, 4'b0001, 8'h2E}, // R7 clr + C
        {1'b1, 8'hFF, 1'b1, 5'b00000, 5'b00000, 4'b0000, 8'hEF}, // R10 S forced
        {1'b1, 8'h10, 1'b1, 5'b11111, 5'b11111, 4'b1000, 8'h00}, // R10 priority
        {1'b1, 8'h08, 1'b0, 5'b00000, 5'b00000, 4'b0000, 8'h18}, // R10 S from V
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b1010, 8'h18}, // R7 take>set
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b0010, 8'h98}, // R6 set
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b0011, 8'h18}, // R7 clr>set
        {1'b0, 8'h00, 1'b0, 5'b00000, 5'b00000, 4'b0101, 8'h18}, // R7 clr>ret
        {1'b0, 8'h00, 1'b1, 5'b00000, 5'b11111, 4'b0000, 8'h18}, // R3 mask 0
        {1'b0, 8'h00, 1'b0, 5'b11111, 5'b11111, 4'b0000, 8'h18}  // R3 no valid
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alu_valid = 1'b0;
    logic [4:0]    alu_mask = '0;
    logic          alu_c = 1'b0, alu_h = 1'b0, alu_v = 1'b0, alu_n = 1'b0, alu_z = 1'b0;
    logic          irq_take = 1'b0, irq_return = 1'b0, ie_set = 1'b0, ie_clear = 1'b0;
    logic          bst_en = 1'b0;
    logic [DW-1:0] bst_operand = '0;
    logic [SW-1:0] bst_sel = '0;
    logic [DW-1:0] bld_operand = '0;
    logic [SW-1:0] bld_sel = '0;
    logic [DW-1:0] bld_result;
    logic          port_wr = 1'b0;
    logic [7:0]    port_wdata = '0;
    logic [7:0]    flags_q;
    logic          t_bit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_flag_reg #(.DATA_W(DW)) u_cpu_flag_reg (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_mask(alu_mask),
        .alu_c(alu_c), .alu_h(alu_h), .alu_v(alu_v), .alu_n(alu_n), .alu_z(alu_z),
        .irq_take(irq_take), .irq_return(irq_return), .ie_set(ie_set),
        .ie_clear(ie_clear), .bst_en(bst_en), .bst_operand(bst_operand),
        .bst_sel(bst_sel), .bld_operand(bld_operand), .bld_sel(bld_sel),
        .bld_result(bld_result), .port_wr(port_wr), .port_wdata(port_wdata),
        .flags_q(flags_q), .t_bit(t_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_valid = 0; alu_mask = '0;
        {alu_h, alu_v, alu_n, alu_z, alu_c} = '0;
        {irq_take, irq_return, ie_set, ie_clear} = '0;
        bst_en = 0; port_wr = 0; port_wdata = '0;
    endtask

    // Apply driven inputs for one edge, then sample after it.
    task automatic step();
        @(posedge clk);
        #2;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset word", 32'(flags_q), 32'h00);
        check("R1 reset t", 32'(t_bit), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            port_wr    = VEC[i][31];
            port_wdata = VEC[i][30:23];
            alu_valid  = VEC[i][22];
            alu_mask   = VEC[i][21:17];
            {alu_h, alu_v, alu_n, alu_z, alu_c} = VEC[i][16:12];
            {irq_take, irq_return, ie_set, ie_clear} = VEC[i][11:8];
            step();
            check($sformatf("R3-table vec %0d (R4 R5 R6 R7 R10)", i),
                  32'(flags_q), 32'(VEC[i][7:0]));
            check($sformatf("R2 t mirror vec %0d", i), 32'(t_bit), 32'(VEC[i][6]));
        end

        // R8: store bit 13 (set) into scratch; word goes 0x18 -> 0x58.
        bst_en = 1; bst_operand = 16'h2000; bst_sel = 4'd13;
        step();
        check("R8 store high bit", 32'(t_bit), 32'h1);
        check("R2 t at bit 6", 32'(flags_q), 32'h58);

        // R9: insert scratch 1 at top bit, then check a clear insert.
        bld_operand = 16'h0000; bld_sel = 4'd15;
        #1 check("R9 insert top", 32'(bld_result), 32'h8000);
        bst_en = 1; bst_operand = 16'hFFFE; bst_sel = 4'd0;
        step();
        check("R8 store bit 0", 32'(t_bit), 32'h0);
        bld_operand = 16'hFFFF; bld_sel = 4'd3;
        #1 check("R9 insert zero", 32'(bld_result), 32'hFFF7);

        // R10: port write beats bit-store in the same cycle.
        bst_en = 1; bst_operand = 16'hFFFF; bst_sel = 4'd7;
        port_wr = 1; port_wdata = 8'h04;
        step();
        check("R10 port over store", 32'(flags_q), 32'h14);

        // R1: mid-run reset clears a full word.
        port_wr = 1; port_wdata = 8'hFF;
        step();
        rst_n = 0;
        @(posedge clk); #2;
        check("R1 mid-run reset", 32'(flags_q), 32'h00);
        @(negedge clk);
        rst_n = 1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule